// File: doc/BRIEF.md
# DSP Register-Transfer Datapath

This block holds the general register file of a small 16-bit signal processor and carries out its register-to-register load instruction. The register set mixes 16-bit and 32-bit registers. It has a constant register that always reads all ones, an accumulator with a separate view of its low half, a product register, the program counter and a port onto a six-entry hardware stack. Each accepted instruction word is decoded in the cycle it is presented. The selected source is converted to the destination's width, and the register file, the stack and the program counter all update on the same clock edge.

Any opcode outside the load class leaves the register file alone. It still advances the program counter and raises a one-cycle `unhandled` strobe, so a neighbouring unit can execute or trap it. A load into the program counter redirects the instruction stream and costs one extra cycle: `instr_ready` drops for exactly one cycle afterwards. Other units read registers combinationally through a read-select port that zero-extends 16-bit registers.

Top module: `dsp_regxfer`

## Requirements
- R1: Register index 0 always reads 0x0000FFFF; a load with destination 0 changes no state except advancing the PC.
- R2: An instruction is a load when instr[15:9] is zero (instr[8] is ignored); the source index is instr[3:0] and the destination index is instr[7:4]. Indices: 1 X, 2 Y, 3 A (32-bit), 4 ST, 5 stack, 6 PC, 7 P (32-bit), 8 to 12 memory-access registers, 13 reserved, 14 memory-access control, 15 AL. The all-zero word therefore acts as a no-operation.
- R3: A 32-bit source (index 3 or 7) loaded into a 16-bit destination delivers its upper 16 bits.
- R4: A 16-bit source loaded into a 32-bit destination writes only the destination's upper 16 bits; the lower 16 bits keep their value.
- R5: A load between two 32-bit registers copies all 32 bits.
- R6: Index 15 reads and writes bits 15:0 of the accumulator and leaves bits 31:16 untouched.
- R7: An instruction is accepted when instr_valid and instr_ready are both high. A load with destination 6 sets the PC to the transferred value and holds instr_ready low for exactly the next cycle, and nothing is accepted during that cycle. Every other accepted instruction adds one to the PC. A source of 6 reads the PC value held before the instruction.
- R8: After reset the PC is 0x0400, the stack is empty, index 5 reads 0x0005, every other register reads zero except index 0, instr_ready is high and both error outputs are low.
- R9: An accepted opcode with instr[15:9] nonzero raises unhandled for exactly the following cycle, changes no register or stack content and adds one to the PC.
- R10: Index 5 as destination pushes the 16-bit transfer value; as source it pops and yields the top entry. The stack is last-in first-out and holds 6 entries. When source and destination are both 5, the pop happens first and the popped value is pushed back.
- R11: A pop from an empty stack yields 0x0005 and a push onto a full stack is discarded; either one sets stack_err, which stays high until reset.
- R12: Index 13 reads zero and ignores writes. The read port returns 16-bit registers zero-extended, and index 5 on the read port shows the top entry without popping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| instr_ready | output | 1 | Low for the cycle after a PC load |
| unhandled | output | 1 | One-cycle strobe after a non-load opcode |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |
| pc | output | 16 | Current program counter |
| rd_sel | input | 4 | Register index for the read port |
| rd_data | output | 32 | Selected register, zero-extended |

## Verification
A corrupted register shows up on the read port one cycle after the load that wrote it, because every index is compared against a bench-side model after every instruction. A wrong width rule appears as a half-word that is wrong or stale in A, P or AL. A wrong stack depth or order appears as a wrong top value, or as stack_err rising on the wrong push or pop. A wrong PC step or a missing stall cycle shows at pc and instr_ready in the cycle that immediately follows the instruction.

// File: rtl/dsp_rx_pkg.sv
package dsp_rx_pkg;

    typedef enum logic [3:0] {
        RI_ONES  = 4'd0,
        RI_X     = 4'd1,
        RI_Y     = 4'd2,
        RI_ACC   = 4'd3,
        RI_STAT  = 4'd4,
        RI_STK   = 4'd5,
        RI_PC    = 4'd6,
        RI_PROD  = 4'd7,
        RI_M0    = 4'd8,
        RI_M1    = 4'd9,
        RI_M2    = 4'd10,
        RI_M3    = 4'd11,
        RI_M4    = 4'd12,
        RI_RSVD  = 4'd13,
        RI_MCTL  = 4'd14,
        RI_ACCLO = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic     load;       // accepted load-class instruction
        logic     bad_op;     // accepted non-load opcode
        reg_idx_e src;
        reg_idx_e dst;
        logic     src_wide;   // source is a 32-bit register
        logic     pop;
        logic     push;
        logic     pc_wr;
    } dec_t;

    function automatic logic is_wide(reg_idx_e idx);
        return (idx == RI_ACC) || (idx == RI_PROD);
    endfunction

endpackage

// File: rtl/rx_decode.sv
module rx_decode
    import dsp_rx_pkg::*;
#(
    parameter int OPW = 16
) (
    input  logic           accept,
    input  logic [OPW-1:0] op,
    output dec_t           dec
);
    localparam int CLS_LSB = 9;

    logic load_class;
    logic unused_op_bit8;

    assign unused_op_bit8 = op[8];
    assign load_class = (op[OPW-1:CLS_LSB] == '0);

    always_comb begin
        dec          = '0;
        dec.src      = reg_idx_e'(op[3:0]);
        dec.dst      = reg_idx_e'(op[7:4]);
        dec.load     = accept && load_class;
        dec.bad_op   = accept && !load_class;
        dec.src_wide = is_wide(dec.src);
        dec.pop      = dec.load && (dec.src == RI_STK);
        dec.push     = dec.load && (dec.dst == RI_STK);
        dec.pc_wr    = dec.load && (dec.dst == RI_PC);
    end
endmodule

// File: rtl/rx_stack.sv
module rx_stack #(
    parameter int              W         = 16,
    parameter int              DEPTH     = 6,
    parameter logic [W-1:0]    EMPTY_VAL = 16'h0005
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pop,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         err
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
        logic                    err;
    } stk_t;

    stk_t s_d, s_q;
    logic [CW-1:0] after_pop;

    always_comb begin
        top_data = EMPTY_VAL;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.cnt == CW'(i + 1)) top_data = s_q.mem[i];
        end
    end

    always_comb begin
        s_d       = s_q;
        after_pop = s_q.cnt;
        if (pop) begin
            if (s_q.cnt == '0) s_d.err = 1'b1;
            else               after_pop = s_q.cnt - CW'(1);
        end
        s_d.cnt = after_pop;
        if (push) begin
            if (after_pop == CW'(DEPTH)) begin
                s_d.err = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (after_pop == CW'(i)) s_d.mem[i] = push_data;
                end
                s_d.cnt = after_pop + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err = s_q.err;
endmodule

// File: rtl/rx_regs.sv
module rx_regs
    import dsp_rx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  reg_idx_e       src,
    input  reg_idx_e       dst,
    input  logic           src_wide,
    input  logic [W-1:0]   pc_val,
    input  logic [W-1:0]   stk_top,
    input  logic [3:0]     rd_sel,
    output logic [W-1:0]   xfer16,
    output logic [2*W-1:0] rd_data
);
    localparam int DW  = 2 * W;
    localparam int PMN = 5;

    typedef struct packed {
        logic [W-1:0]          x;
        logic [W-1:0]          y;
        logic [W-1:0]          st;
        logic [PMN-1:0][W-1:0] pm;
        logic [W-1:0]          mctl;
        logic [DW-1:0]         acc;
        logic [DW-1:0]         prod;
    } rf_t;

    rf_t r_d, r_q;
    logic [DW-1:0] xfer32;

    function automatic logic [W-1:0] view16(rf_t r, reg_idx_e i,
                                            logic [W-1:0] pcv,
                                            logic [W-1:0] tos);
        logic [W-1:0] v;
        case (i)
            RI_ONES:  v = '1;
            RI_X:     v = r.x;
            RI_Y:     v = r.y;
            RI_ACC:   v = r.acc[DW-1:W];
            RI_STAT:  v = r.st;
            RI_STK:   v = tos;
            RI_PC:    v = pcv;
            RI_PROD:  v = r.prod[DW-1:W];
            RI_M0:    v = r.pm[0];
            RI_M1:    v = r.pm[1];
            RI_M2:    v = r.pm[2];
            RI_M3:    v = r.pm[3];
            RI_M4:    v = r.pm[4];
            RI_MCTL:  v = r.mctl;
            RI_ACCLO: v = r.acc[W-1:0];
            default:  v = '0;
        endcase
        return v;
    endfunction

    assign xfer16 = view16(r_q, src, pc_val, stk_top);
    assign xfer32 = (src == RI_ACC) ? r_q.acc : r_q.prod;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (dst)
                RI_X:     r_d.x    = xfer16;
                RI_Y:     r_d.y    = xfer16;
                RI_STAT:  r_d.st   = xfer16;
                RI_M0:    r_d.pm[0] = xfer16;
                RI_M1:    r_d.pm[1] = xfer16;
                RI_M2:    r_d.pm[2] = xfer16;
                RI_M3:    r_d.pm[3] = xfer16;
                RI_M4:    r_d.pm[4] = xfer16;
                RI_MCTL:  r_d.mctl = xfer16;
                RI_ACCLO: r_d.acc[W-1:0] = xfer16;
                RI_ACC: begin
                    if (src_wide) r_d.acc = xfer32;
                    else          r_d.acc[DW-1:W] = xfer16;
                end
                RI_PROD: begin
                    if (src_wide) r_d.prod = xfer32;
                    else          r_d.prod[DW-1:W] = xfer16;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_idx_e'(rd_sel))
            RI_ACC:  rd_data = r_q.acc;
            RI_PROD: rd_data = r_q.prod;
            default: rd_data = {{W{1'b0}},
                                view16(r_q, reg_idx_e'(rd_sel), pc_val, stk_top)};
        endcase
    end
endmodule

// File: rtl/dsp_regxfer.sv
module dsp_regxfer
    import dsp_rx_pkg::*;
#(
    parameter int           W         = 16,
    parameter int           STK_DEPTH = 6,
    parameter logic [W-1:0] PC_RESET  = 16'h0400,
    parameter logic [W-1:0] STK_EMPTY = 16'h0005
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           instr_valid,
    input  logic [W-1:0]   instr,
    output logic           instr_ready,
    output logic           unhandled,
    output logic           stack_err,
    output logic [W-1:0]   pc,
    input  logic [3:0]     rd_sel,
    output logic [2*W-1:0] rd_data
);
    typedef struct packed {
        logic [W-1:0] pc;
        logic         stall;
        logic         unh;
    } ctl_t;

    ctl_t c_d, c_q;
    dec_t dec;
    logic accept;
    logic [W-1:0] xfer16;
    logic [W-1:0] stk_top;

    assign accept = instr_valid && !c_q.stall;

    rx_decode #(.OPW(W)) u_dec (
        .accept (accept),
        .op     (instr),
        .dec    (dec)
    );

    rx_stack #(.W(W), .DEPTH(STK_DEPTH), .EMPTY_VAL(STK_EMPTY)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (dec.pop),
        .push      (dec.push),
        .push_data (xfer16),
        .top_data  (stk_top),
        .err       (stack_err)
    );

    rx_regs #(.W(W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec.load),
        .src      (dec.src),
        .dst      (dec.dst),
        .src_wide (dec.src_wide),
        .pc_val   (c_q.pc),
        .stk_top  (stk_top),
        .rd_sel   (rd_sel),
        .xfer16   (xfer16),
        .rd_data  (rd_data)
    );

    always_comb begin
        c_d       = c_q;
        c_d.stall = dec.pc_wr;
        c_d.unh   = dec.bad_op;
        if (accept) begin
            if (dec.pc_wr) c_d.pc = xfer16;
            else           c_d.pc = c_q.pc + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.pc    <= PC_RESET;
            c_q.stall <= 1'b0;
            c_q.unh   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign instr_ready = !c_q.stall;
    assign unhandled   = c_q.unh;
    assign pc          = c_q.pc;
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           instr_valid,
    input logic [W-1:0]   instr,
    input logic           instr_ready,
    input logic           unhandled,
    input logic           stack_err,
    input logic [W-1:0]   pc,
    input logic [3:0]     rd_sel,
    input logic [2*W-1:0] rd_data
);
    logic acc_load, acc_bad, acc_pcw;
    assign acc_load = instr_valid && instr_ready && (instr[W-1:9] == '0);
    assign acc_bad  = instr_valid && instr_ready && (instr[W-1:9] != '0);
    assign acc_pcw  = acc_load && (instr[7:4] == 4'd6);

    p_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 4'd0) |-> (rd_data == {{W{1'b0}}, {W{1'b1}}}));

    p_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 4'd13) |-> (rd_data == '0));

    p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_ready && !acc_pcw) |=> (pc == $past(pc) + W'(1)));

    p_pc_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pcw |=> !instr_ready);

    p_stall_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |=> instr_ready);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |=> $stable(pc));

    p_unh_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bad |=> unhandled);

    p_unh_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_bad |=> !unhandled);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
endmodule

bind dsp_regxfer rx_checker #(.W(W)) u_rx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .instr_ready (instr_ready),
    .unhandled   (unhandled),
    .stack_err   (stack_err),
    .pc          (pc),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data)
);

// File: tb/dsp_regxfer_bench.sv
`timescale 1ns/100ps
module dsp_regxfer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        instr_ready, unhandled, stack_err;
    logic [15:0] pc;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [15:0] m16 [16];
    logic [31:0] ma, mp;
    logic [15:0] mpc;
    logic [15:0] mstk [6];
    int          mdep;
    bit          merr, m_unh, m_pcw;

    dsp_regxfer u_dsp_regxfer (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .instr_ready(instr_ready), .unhandled(unhandled), .stack_err(stack_err),
        .pc(pc), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_top();
        return (mdep == 0) ? 16'h0005 : mstk[mdep-1];
    endfunction

    function automatic logic [15:0] m_src16(int s);
        case (s)
            0: return 16'hFFFF;
            3: return ma[31:16];
            5: return m_top();
            6: return mpc;
            7: return mp[31:16];
            13: return 16'h0000;
            15: return ma[15:0];
            default: return m16[s];
        endcase
    endfunction

    function automatic logic [31:0] m_rd(int i);
        if (i == 3) return ma;
        if (i == 7) return mp;
        return {16'h0000, m_src16(i)};
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0: return "R1";
            5: return "R10";
            6: return "R7";
            13: return "R12";
            15: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m16[i] = '0;
        ma = '0; mp = '0; mpc = 16'h0400; mdep = 0; merr = 0;
        m_unh = 0; m_pcw = 0;
    endtask

    task automatic model(logic [15:0] op);
        int s, d;
        logic [15:0] v;
        logic [31:0] w;
        m_unh = 0; m_pcw = 0;
        if (op[15:9] != 0) begin
            m_unh = 1;
            mpc = mpc + 16'd1;
            return;
        end
        s = int'(op[3:0]);
        d = int'(op[7:4]);
        v = m_src16(s);
        w = (s == 3) ? ma : mp;
        if (s == 5) begin
            if (mdep == 0) merr = 1; else mdep--;
        end
        case (d)
            3: if (s == 3 || s == 7) ma = w; else ma[31:16] = v;
            7: if (s == 3 || s == 7) mp = w; else mp[31:16] = v;
            15: ma[15:0] = v;
            5: if (mdep == 6) merr = 1; else begin mstk[mdep] = v; mdep++; end
            6: begin mpc = v; m_pcw = 1; end
            0, 13: ;
            default: m16[d] = v;
        endcase
        if (d != 6) mpc = mpc + 16'd1;
    endtask

    task automatic verify_all();
        check("R9 unhandled", {31'd0, unhandled}, {31'd0, m_unh});
        check("R7 ready", {31'd0, instr_ready}, {31'd0, !m_pcw});
        check("R7 pc", {16'd0, pc}, {16'd0, mpc});
        check("R11 stack_err", {31'd0, stack_err}, {31'd0, merr});
        for (int i = 0; i < 16; i++) begin
            rd_sel = 4'(i);
            #0.2;
            check(tag_of(i), rd_data, m_rd(i));
        end
    endtask

    task automatic check_reg(string tag, int i);
        rd_sel = 4'(i);
        #0.2;
        check(tag, rd_data, m_rd(i));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; instr_valid = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        model_reset();
        @(negedge clk);
        verify_all();
    endtask

    task automatic do_instr(logic [15:0] op);
        @(negedge clk);
        instr_valid = 1; instr = op;
        @(posedge clk);
        model(op);
        #1 instr_valid = 0;
        @(negedge clk);
        verify_all();
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R8 reset state
        do_reset();
        check_reg("R8 stack empty read", 5);
        check("R8 pc", {16'd0, pc}, 32'h0000_0400);

        // width rules
        do_instr(16'h0016);                 // X <- PC
        do_instr(16'h0031);                 // A <- X (16 to 32)
        check_reg("R4 upper only", 3);
        do_instr(16'h00F0);                 // AL <- ones
        check_reg("R6 AL write", 3);
        do_instr(16'h0023);                 // Y <- A (32 to 16)
        check_reg("R3 upper half", 2);
        do_instr(16'h0073);                 // P <- A (32 to 32)
        check_reg("R5 full copy", 7);
        do_instr(16'h0030);                 // A <- ones, low kept
        check_reg("R4 low kept", 3);
        do_instr(16'h004F);                 // ST <- AL
        check_reg("R6 AL read", 4);
        do_instr(16'h0170);                 // bit 8 set, still a load
        check_reg("R2 bit8 ignored", 7);
        do_instr(16'h0000);                 // no-op
        check("R2 nop pc", {16'd0, pc}, {16'd0, mpc});

        // constant and reserved indices
        do_instr(16'h0001);                 // ones <- X
        check_reg("R1 ones write ignored", 0);
        do_instr(16'h00D1);                 // reserved <- X
        check_reg("R12 reserved write ignored", 13);

        // unhandled
        do_instr(16'h0213);
        check_reg("R9 A unchanged", 3);
        do_instr(16'hFE41);

        // underflow
        do_reset();
        do_instr(16'h0015);                 // X <- stack (empty)
        check_reg("R11 underflow value", 1);
        check("R11 err set", {31'd0, stack_err}, 32'd1);
        do_instr(16'h0010);
        check("R11 err sticky", {31'd0, stack_err}, 32'd1);

        // LIFO and overflow
        do_reset();
        for (int k = 0; k < 7; k++) do_instr(16'h0056);   // stack <- PC
        check("R11 overflow err", {31'd0, stack_err}, 32'd1);
        check_reg("R11 overflow top kept", 5);
        do_instr(16'h0055);                 // stack <- stack
        check_reg("R10 pop then push", 5);
        for (int k = 0; k < 6; k++) begin
            do_instr(16'h0015);
            check_reg("R10 lifo order", 1);
        end

        // PC load with a held instruction during the stall
        do_reset();
        @(negedge clk);
        instr_valid = 1; instr = 16'h0060;  // PC <- ones
        @(posedge clk);
        model(16'h0060);
        @(negedge clk);
        instr = 16'h0016;                   // X <- PC, held
        check("R7 stall", {31'd0, instr_ready}, 32'd0);
        check("R7 pc load", {16'd0, pc}, 32'h0000_FFFF);
        @(posedge clk);
        @(negedge clk);
        check_reg("R7 not accepted in stall", 1);
        check("R7 ready back", {31'd0, instr_ready}, 32'd1);
        @(posedge clk);
        model(16'h0016);
        #1 instr_valid = 0;
        @(negedge clk);
        verify_all();

        // random mix
        for (int n = 0; n < 500; n++) begin
            logic [15:0] op;
            if ($urandom_range(0, 9) < 8)
                op = {7'd0, 1'($urandom), 8'($urandom)};
            else
                op = {7'($urandom_range(1, 127)), 9'($urandom)};
            do_instr(op);
            if (n == 250) do_reset();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule